// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte scratch data memory of an 8-bit controller core. One flop array stands behind four views. A working-register view picks one of eight registers in one of four banks. A byte view reaches any location by its 7-bit address. A bit view reads, sets or clears a single flag in the sixteen bytes from 20h to 2Fh. A stack view pushes and pops through a stack pointer kept inside the block.

Each view has its own request strobe. In any cycle the block serves one request, chosen by fixed priority, and drops the others. Read results are registered and are returned with a valid strobe one cycle later. An address outside 00h–7Fh on the byte, bit or stack path is refused with an error pulse. Such an address never wraps onto a legal location.

Top module: `bdram_top`

## Requirements
- R1: After reset the stack pointer output is 07h, `rd_valid` and `addr_err` are 0, and the selected register bank is 0. A register write to R3 with no bank load therefore lands in byte 03h.
- R2: A byte read of address a (00h–7Fh) returns the stored byte on `rd_data`, with `rd_valid` high, in the cycle after the request. A byte write stores `byte_wdata` at a and leaves `rd_valid` low.
- R3: A register access reaches byte bank×8 + `reg_num`, where bank is the stored 2-bit bank select. A bank load (`bank_we`) takes effect from the following cycle. A register access in the same cycle as the load still uses the old bank.
- R4: A bit read of bit address n (00h–7Fh) returns bit n&7 of byte 20h + (n>>3) on `rd_bit`, with `rd_valid` high, one cycle after the request.
- R5: A bit write with `bit_val`=1 sets the addressed bit and one with `bit_val`=0 clears it. The other seven bits of that byte do not change.
- R6: A push first increments the stack pointer and then writes `push_data` at the new pointer. From reset, pushes of 25h, 12h and F3h land at 08h, 09h and 0Ah and leave the pointer at 0Ah.
- R7: A pop returns the byte at the current pointer, one cycle later with `rd_valid`, and then decrements the pointer. Three pops after the pushes of R6 return F3h, 12h and 25h and restore 07h.
- R8: The following requests are refused: a byte address above 7Fh, a bit address above 7Fh, a push whose new pointer would exceed 7Fh, and a pop while the pointer is above 7Fh. A refused request writes nothing, leaves the pointer unchanged, and gives `addr_err`=1 with `rd_valid`=0 in the next cycle.
- R9: When several requests arrive in one cycle, only the highest-priority one takes effect. The order is byte, then register, then bit, then push, then pop. A byte write therefore beats a bit write to the same byte, and a push beats a pop.
- R10: `sp` always shows the current stack pointer, updated at the edge that completes a push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Load the bank select |
| bank_in | input | 2 | New bank number |
| reg_en | input | 1 | Register-view request |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_num | input | 3 | Register number within the bank |
| reg_wdata | input | 8 | Register write data |
| byte_en | input | 1 | Byte-view request |
| byte_we | input | 1 | Byte write (1) or read (0) |
| byte_addr | input | 8 | Byte address |
| byte_wdata | input | 8 | Byte write data |
| bit_en | input | 1 | Bit-view request |
| bit_we | input | 1 | Bit write (1) or read (0) |
| bit_addr | input | 8 | Bit address |
| bit_val | input | 1 | Value given to the bit on a write |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | 8 | Byte to push |
| rd_data | output | 8 | Registered read data |
| rd_bit | output | 1 | Registered bit-read result |
| rd_valid | output | 1 | Read result valid this cycle |
| addr_err | output | 1 | Previous request was refused |
| sp | output | 8 | Current stack pointer |

## Verification
Any two views can be requested in the same cycle. The sharpest case is a byte write and a bit set aimed at the same byte, because both read and rewrite that byte. The bench raises both strobes in one cycle and then reads the byte back. It expects the whole-byte value, with no trace of the bit change. It pairs a byte write with a push the same way and expects the stack pointer to stay put. It also pairs a register read with a bit read, and a push with a pop, and judges the winner from `rd_data`, `rd_valid` and `sp`.

// File: rtl/bdram_pkg.sv
package bdram_pkg;
    localparam int ADDR_W   = 7;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 2;
    localparam int REG_W    = 3;
    localparam int POS_W    = $clog2(DATA_W);
    localparam int BIT_BASE = 32;
    localparam logic [8:0] LIMIT9 = 9'(DEPTH - 1);

    typedef enum logic [2:0] {
        OP_IDLE, OP_RD, OP_WR, OP_BRD, OP_BWR, OP_PUSH, OP_POP
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [POS_W-1:0]  bpos;
        logic              bval;
        logic              err;
    } grant_t;

    typedef struct packed {
        logic [7:0]        sp;
        logic [BANK_W-1:0] bank;
        logic [DATA_W-1:0] rdata;
        logic              rbit;
        logic              rvalid;
        logic              err;
    } state_t;
endpackage

// File: rtl/bdram_arb.sv
module bdram_arb
    import bdram_pkg::*;
(
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [BANK_W-1:0] bank,
    input  logic              byte_en,
    input  logic              byte_we,
    input  logic [7:0]        byte_addr,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic              bit_en,
    input  logic              bit_we,
    input  logic [7:0]        bit_addr,
    input  logic              bit_val,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    input  logic [7:0]        sp,
    output grant_t            grant
);
    logic [8:0] sp_inc;

    always_comb begin
        sp_inc = {1'b0, sp} + 9'd1;
        grant  = '0;
        grant.op = OP_IDLE;
        if (byte_en) begin
            if ({1'b0, byte_addr} > LIMIT9) begin
                grant.err = 1'b1;
            end else begin
                grant.op    = byte_we ? OP_WR : OP_RD;
                grant.addr  = byte_addr[ADDR_W-1:0];
                grant.wdata = byte_wdata;
            end
        end else if (reg_en) begin
            grant.op    = reg_we ? OP_WR : OP_RD;
            grant.addr  = ADDR_W'({bank, reg_num});
            grant.wdata = reg_wdata;
        end else if (bit_en) begin
            if ({1'b0, bit_addr} > LIMIT9) begin
                grant.err = 1'b1;
            end else begin
                grant.op   = bit_we ? OP_BWR : OP_BRD;
                grant.addr = ADDR_W'(BIT_BASE) + ADDR_W'(bit_addr[ADDR_W-1:POS_W]);
                grant.bpos = bit_addr[POS_W-1:0];
                grant.bval = bit_val;
            end
        end else if (push) begin
            if (sp_inc > LIMIT9) begin
                grant.err = 1'b1;
            end else begin
                grant.op    = OP_PUSH;
                grant.addr  = sp_inc[ADDR_W-1:0];
                grant.wdata = push_data;
            end
        end else if (pop) begin
            if ({1'b0, sp} > LIMIT9) begin
                grant.err = 1'b1;
            end else begin
                grant.op   = OP_POP;
                grant.addr = sp[ADDR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bdram_bitmerge.sv
module bdram_bitmerge
    import bdram_pkg::*;
(
    input  logic [DATA_W-1:0] old_byte,
    input  logic [POS_W-1:0]  pos,
    input  logic              val,
    output logic [DATA_W-1:0] new_byte
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign new_byte[i] = (pos == POS_W'(i)) ? val : old_byte[i];
    end
endmodule

// File: rtl/bdram_top.sv
module bdram_top
    import bdram_pkg::*;
#(
    parameter logic [7:0] SP_INIT = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [1:0]        bank_in,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_num,
    input  logic [7:0]        reg_wdata,
    input  logic              byte_en,
    input  logic              byte_we,
    input  logic [7:0]        byte_addr,
    input  logic [7:0]        byte_wdata,
    input  logic              bit_en,
    input  logic              bit_we,
    input  logic [7:0]        bit_addr,
    input  logic              bit_val,
    input  logic              push,
    input  logic              pop,
    input  logic [7:0]        push_data,
    output logic [7:0]        rd_data,
    output logic              rd_bit,
    output logic              rd_valid,
    output logic              addr_err,
    output logic [7:0]        sp
);
    state_t            s_d, s_q;
    grant_t            g;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_byte, bit_new, mem_wdata_d;
    logic              mem_we_d;

    bdram_arb u_arb (
        .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
        .bank(s_q.bank),
        .byte_en(byte_en), .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
        .push(push), .pop(pop), .push_data(push_data),
        .sp(s_q.sp), .grant(g)
    );

    assign rd_byte = mem[g.addr];

    bdram_bitmerge u_merge (
        .old_byte(rd_byte), .pos(g.bpos), .val(g.bval), .new_byte(bit_new)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rvalid  = 1'b0;
        s_d.err     = g.err;
        mem_we_d    = 1'b0;
        mem_wdata_d = g.wdata;
        if (bank_we) s_d.bank = bank_in;
        case (g.op)
            OP_RD: begin
                s_d.rdata  = rd_byte;
                s_d.rvalid = 1'b1;
            end
            OP_WR: mem_we_d = 1'b1;
            OP_BRD: begin
                s_d.rdata  = rd_byte;
                s_d.rbit   = rd_byte[g.bpos];
                s_d.rvalid = 1'b1;
            end
            OP_BWR: begin
                mem_we_d    = 1'b1;
                mem_wdata_d = bit_new;
            end
            OP_PUSH: begin
                mem_we_d = 1'b1;
                s_d.sp   = s_q.sp + 8'd1;
            end
            OP_POP: begin
                s_d.rdata  = rd_byte;
                s_d.rvalid = 1'b1;
                s_d.sp     = s_q.sp - 8'd1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sp   <= SP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we_d) mem[g.addr] <= mem_wdata_d;
    end

    assign rd_data  = s_q.rdata;
    assign rd_bit   = s_q.rbit;
    assign rd_valid = s_q.rvalid;
    assign addr_err = s_q.err;
    assign sp       = s_q.sp;

    a_r6_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (g.op == OP_PUSH) |=> (sp == $past(sp) + 8'd1));
    a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (g.op == OP_POP) |=> (sp == $past(sp) - 8'd1));
    a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        g.err |-> !mem_we_d);
    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        g.err |=> (addr_err && !rd_valid && $stable(sp)));
    a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (g.op == OP_BWR) |-> ($countones(bit_new ^ rd_byte) <= 1));
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (g.op == OP_RD || g.op == OP_BRD || g.op == OP_POP) |=> rd_valid);
endmodule

// File: tb/bdram_top_tb.sv
`timescale 1ns/1ps
module bdram_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_we = 0; logic [1:0] bank_in = 0;
    logic reg_en = 0, reg_we = 0; logic [2:0] reg_num = 0; logic [7:0] reg_wdata = 0;
    logic byte_en = 0, byte_we = 0; logic [7:0] byte_addr = 0, byte_wdata = 0;
    logic bit_en = 0, bit_we = 0, bit_val = 0; logic [7:0] bit_addr = 0;
    logic push = 0, pop = 0; logic [7:0] push_data = 0;
    logic [7:0] rd_data, sp; logic rd_bit, rd_valid, addr_err;

    int checks = 0, errors = 0;
    logic [7:0] mdl [128];
    bit done = 0;

    always #2 clk = ~clk;

    bdram_top u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in;
        bank_we = 0; reg_en = 0; reg_we = 0; byte_en = 0; byte_we = 0;
        bit_en = 0; bit_we = 0; push = 0; pop = 0;
    endtask

    task automatic step;
        @(negedge clk);
        clear_in();
    endtask

    task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
        byte_en = 1; byte_we = 1; byte_addr = a; byte_wdata = d; step();
        if (a < 8'h80) mdl[a[6:0]] = d;
    endtask

    task automatic byte_rd(input logic [7:0] a, output logic [7:0] d);
        byte_en = 1; byte_we = 0; byte_addr = a; step(); d = rd_data;
    endtask

    task automatic do_reset;
        rst_n = 0; clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        do_reset();
        chk(sp == 8'h07, "R1 sp", sp, 8'h07);
        chk(!rd_valid && !addr_err, "R1 flags", {rd_valid, addr_err}, 0);
        chk(sp == 8'h07, "R10 sp output", sp, 8'h07);
        reg_en = 1; reg_we = 1; reg_num = 3; reg_wdata = 8'hA5; step(); mdl[3] = 8'hA5;
        byte_rd(8'h03, d);
        chk(d == 8'hA5, "R1 bank0", d, 8'hA5);

        // R2 sweep
        for (int a = 0; a < 128; a++) byte_wr(8'(a), 8'((a * 37 + 5) & 255));
        chk(!rd_valid, "R2 write no valid", rd_valid, 0);
        for (int a = 0; a < 128; a++) begin
            byte_rd(8'(a), d);
            chk(d == mdl[a] && rd_valid, "R2 byte read", d, mdl[a]);
        end

        // R3 register view per bank
        for (int b = 0; b < 4; b++) begin
            bank_we = 1; bank_in = 2'(b); step();
            for (int r = 0; r < 8; r++) begin
                reg_en = 1; reg_we = 0; reg_num = 3'(r); step();
                chk(rd_data == mdl[b*8+r] && rd_valid, "R3 reg read", rd_data, mdl[b*8+r]);
            end
            reg_en = 1; reg_we = 1; reg_num = 3'd6; reg_wdata = 8'(8'hC0 + b); step();
            mdl[b*8+6] = 8'(8'hC0 + b);
            byte_rd(8'(b*8+6), d);
            chk(d == mdl[b*8+6], "R3 reg write", d, mdl[b*8+6]);
        end
        bank_we = 1; bank_in = 2'd1; step();
        bank_we = 1; bank_in = 2'd2; reg_en = 1; reg_num = 3'd5; step();
        chk(rd_data == mdl[13], "R3 old bank same cycle", rd_data, mdl[13]);
        reg_en = 1; reg_num = 3'd5; step();
        chk(rd_data == mdl[21], "R3 new bank next cycle", rd_data, mdl[21]);

        // R4 bit reads
        for (int n = 0; n < 128; n++) begin
            bit_en = 1; bit_we = 0; bit_addr = 8'(n); step();
            chk(rd_bit == mdl[32 + n/8][n%8] && rd_valid, "R4 bit read", rd_bit, mdl[32 + n/8][n%8]);
        end

        // R5 bit writes
        byte_wr(8'h24, 8'h00);
        bit_en = 1; bit_we = 1; bit_val = 1; bit_addr = 8'h25; step();
        byte_rd(8'h24, d);
        chk(d == 8'h20, "R5 set bit 25h", d, 8'h20);
        mdl[8'h24] = 8'h20;
        for (int n = 0; n < 128; n++) begin
            if (n % 3 != 2) begin
                bit_en = 1; bit_we = 1; bit_val = (n % 3 == 0); bit_addr = 8'(n); step();
                mdl[32 + n/8][n%8] = (n % 3 == 0);
            end
        end
        for (int a = 32; a < 48; a++) begin
            byte_rd(8'(a), d);
            chk(d == mdl[a], "R5 neighbours kept", d, mdl[a]);
        end

        // R8 out of range
        for (int a = 128; a < 256; a++) begin
            byte_wr(8'(a), 8'h5A);
            chk(addr_err && !rd_valid, "R8 byte err", {addr_err, rd_valid}, 2);
        end
        byte_rd(8'hC3, d);
        chk(addr_err && !rd_valid, "R8 byte read err", {addr_err, rd_valid}, 2);
        bit_en = 1; bit_we = 1; bit_val = 1; bit_addr = 8'h90; step();
        chk(addr_err, "R8 bit err", addr_err, 1);
        for (int a = 0; a < 128; a++) begin
            byte_rd(8'(a), d);
            chk(d == mdl[a], "R8 no write", d, mdl[a]);
        end

        // R6 / R7 stack
        do_reset();
        push = 1; push_data = 8'h25; step(); mdl[8] = 8'h25;
        chk(sp == 8'h08, "R6 sp", sp, 8'h08);
        push = 1; push_data = 8'h12; step(); mdl[9] = 8'h12;
        push = 1; push_data = 8'hF3; step(); mdl[10] = 8'hF3;
        chk(sp == 8'h0A, "R6 sp 0A", sp, 8'h0A);
        for (int a = 8; a < 11; a++) begin
            byte_rd(8'(a), d);
            chk(d == mdl[a], "R6 stack bytes", d, mdl[a]);
        end
        pop = 1; step(); chk(rd_data == 8'hF3 && rd_valid, "R7 pop1", rd_data, 8'hF3);
        pop = 1; step(); chk(rd_data == 8'h12, "R7 pop2", rd_data, 8'h12);
        pop = 1; step(); chk(rd_data == 8'h25, "R7 pop3", rd_data, 8'h25);
        chk(sp == 8'h07, "R7 sp restored", sp, 8'h07);

        // R8 stack top
        for (int i = 0; i < 120; i++) begin
            push = 1; push_data = 8'(i); step(); mdl[8+i] = 8'(i);
        end
        chk(sp == 8'h7F, "R10 sp top", sp, 8'h7F);
        push = 1; push_data = 8'hEE; step();
        chk(addr_err && sp == 8'h7F, "R8 push overflow", sp, 8'h7F);
        pop = 1; step();
        chk(rd_data == 8'd119 && sp == 8'h7E, "R8 top intact", rd_data, 119);

        // R9 priority
        bit_en = 1; bit_we = 1; bit_val = 1; bit_addr = 8'h20;
        byte_en = 1; byte_we = 1; byte_addr = 8'h24; byte_wdata = 8'h3C; step();
        mdl[8'h24] = 8'h3C;
        byte_rd(8'h24, d);
        chk(d == 8'h3C, "R9 byte beats bit", d, 8'h3C);
        push = 1; push_data = 8'h77;
        byte_en = 1; byte_we = 1; byte_addr = 8'h30; byte_wdata = 8'h44; step();
        mdl[8'h30] = 8'h44;
        chk(sp == 8'h7E, "R9 push dropped", sp, 8'h7E);
        byte_rd(8'h30, d);
        chk(d == 8'h44, "R9 byte done", d, 8'h44);
        bank_we = 1; bank_in = 0; step();
        reg_en = 1; reg_we = 0; reg_num = 3'd3;
        bit_en = 1; bit_we = 0; bit_addr = 8'h00; step();
        chk(rd_data == mdl[3] && rd_valid, "R9 reg beats bit", rd_data, mdl[3]);
        pop = 1; step();
        push = 1; pop = 1; push_data = 8'h99; step();
        chk(sp == 8'h7E, "R9 push beats pop", sp, 8'h7E);
        chk(!rd_valid, "R9 pop dropped", rd_valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule